// File: doc/BRIEF.md
# Descriptor Command Execution Engine

This block performs the memory work of a single, already decoded transfer descriptor. Once started it runs one of four byte operations: copy, a four-term bitwise logic mix of source and destination, swap, or fill. It runs the operation once per iteration and issues each byte access through one request/acknowledge memory port. A select line on that port chooses between the source and the destination address channel. The address units outside the block own the actual addresses. The engine only tells them when to step forward and when a row has ended, so that they can apply their modulo offset.

The iteration count comes from a 16-bit field. When neither channel uses modulo addressing, the field is one linear length. When either channel uses modulo addressing, the low half counts columns and the high half counts rows. An optional key byte can suppress any write whose data equals the key, and the addresses still advance past it. When the last iteration finishes, the engine pulses done to the list fetcher and becomes idle.

Top module: `dma_exec_engine`

## Requirements
- R1: Command code 0 (cmd_byte[1:0]) copies: each iteration issues one source read (mem_dst=0), then one destination write of that byte, then advances both channels.
- R2: Command code 1 mixes: each iteration reads source S and then destination D, and writes to the destination the OR of the enabled terms. cmd_byte[4] enables ~S&~D, cmd_byte[5] enables ~S&D, cmd_byte[6] enables S&~D and cmd_byte[7] enables S&D.
- R3: Command code 2 swaps: each iteration reads source and destination, writes the source byte to the destination, then writes the destination byte to the source.
- R4: Command code 3 fills: each iteration writes fill_byte to the destination with one write, and makes no source access, no source step and no source row advance.
- R5: With src_mod and dst_mod both clear, count is a linear iteration count, and 0 means 65536 iterations.
- R6: With src_mod or dst_mod set, count[7:0] is the column count and count[15:8] is the row count, and a value of 0 in either means 256. The block runs rows × columns iterations. In the advance cycle of each row's last column it pulses src_row (if src_mod is set) and dst_row (if dst_mod is set), together with the step pulses.
- R7: With key_en set, a write whose data equals key_val makes no memory request, and the channels still step.
- R8: done is high for exactly one cycle, in the cycle after the final access of the last iteration completes, and busy drops on the next cycle.
- R9: start is ignored while busy. All descriptor inputs are captured on the accepted start.
- R10: After reset, busy, done, mem_req and all step and row pulses are low.
- R11: A request holds mem_req, mem_we, mem_dst and mem_wdata steady until mem_ack, and step pulses never coincide with a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing the presented descriptor |
| cmd_byte | input | 8 | Command code in [1:0], minterm enables in [7:4] |
| count | input | 16 | Iteration count, or rows:columns in modulo mode |
| src_mod | input | 1 | Source channel uses modulo addressing |
| dst_mod | input | 1 | Destination channel uses modulo addressing |
| fill_byte | input | 8 | Byte written by the fill command |
| key_en | input | 1 | Enable write suppression by key |
| key_val | input | 8 | Key byte that suppresses writes |
| busy | output | 1 | Descriptor in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_dst | output | 1 | 1 selects the destination address, 0 the source |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| src_step | output | 1 | Advance the source address |
| dst_step | output | 1 | Advance the destination address |
| src_row | output | 1 | Apply the source modulo at row end |
| dst_row | output | 1 | Apply the destination modulo at row end |

## Verification
The hardest cases to reach are the count boundaries: a linear count of 0, which means 65536 iterations, and row or column values of 0, which mean 256. At ordinary access latency a full 65536-iteration run would not fit the cycle budget. The stimulus therefore runs a fill whose byte equals an enabled key, so that every write is suppressed and each iteration costs two cycles. The bench then counts destination steps and writes. Modulo runs with a zero column or a zero row are directed cases. Random runs use a small byte alphabet so that key matches occur often, and they re-pulse start while the block is busy.

// File: rtl/dma_exec_engine.sv
module dma_exec_engine #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    cmd_byte,
  input  logic [CW-1:0] count,
  input  logic          src_mod,
  input  logic          dst_mod,
  input  logic [DW-1:0] fill_byte,
  input  logic          key_en,
  input  logic [DW-1:0] key_val,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dst,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          src_step,
  output logic          dst_step,
  output logic          src_row,
  output logic          dst_row
);
  localparam int H = CW / 2;
  localparam logic [1:0] OP_COPY = 2'd0, OP_MIX = 2'd1, OP_SWAP = 2'd2, OP_FILL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RDS, S_RDD, S_WRD, S_WRS, S_ADV} st_t;
  st_t st;

  logic [1:0]    op;
  logic [3:0]    mt;
  logic          modm, smod, dmod, ken;
  logic [DW-1:0] fillv, kval, sbuf, dbuf;
  logic [CW-1:0] cnt;
  logic [H-1:0]  col_init;

  logic [DW-1:0] mixv, wval;
  logic          skip, row_end, last, adv, is_fill;

  assign mixv = ({DW{mt[0]}} & ~sbuf & ~dbuf) | ({DW{mt[1]}} & ~sbuf & dbuf)
              | ({DW{mt[2]}} &  sbuf & ~dbuf) | ({DW{mt[3]}} &  sbuf & dbuf);
  assign wval = (st == S_WRS)   ? dbuf :
                (op == OP_MIX)  ? mixv :
                (op == OP_FILL) ? fillv : sbuf;
  assign skip    = ken && (wval == kval);
  assign is_fill = (op == OP_FILL);

  assign row_end = modm && (cnt[H-1:0] == H'(1));
  assign last    = modm ? (row_end && cnt[CW-1:H] == H'(1)) : (cnt == CW'(1));
  assign adv     = (st == S_ADV);

  assign busy      = (st != S_IDLE);
  assign done      = adv && last;
  assign mem_we    = (st == S_WRD) || (st == S_WRS);
  assign mem_req   = (st == S_RDS) || (st == S_RDD) || (mem_we && !skip);
  assign mem_dst   = (st == S_RDD) || (st == S_WRD);
  assign mem_wdata = wval;
  assign src_step  = adv && !is_fill;
  assign dst_step  = adv;
  assign src_row   = adv && row_end && smod && !is_fill;
  assign dst_row   = adv && row_end && dmod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op       <= OP_COPY;
      mt       <= '0;
      modm     <= 1'b0;
      smod     <= 1'b0;
      dmod     <= 1'b0;
      ken      <= 1'b0;
      fillv    <= '0;
      kval     <= '0;
      sbuf     <= '0;
      dbuf     <= '0;
      cnt      <= '0;
      col_init <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op       <= cmd_byte[1:0];
          mt       <= cmd_byte[7:4];
          modm     <= src_mod || dst_mod;
          smod     <= src_mod;
          dmod     <= dst_mod;
          ken      <= key_en;
          kval     <= key_val;
          fillv    <= fill_byte;
          cnt      <= count;
          col_init <= count[H-1:0];
          st       <= (cmd_byte[1:0] == OP_FILL) ? S_WRD : S_RDS;
        end
        S_RDS: if (mem_ack) begin
          sbuf <= mem_rdata;
          st   <= (op == OP_COPY) ? S_WRD : S_RDD;
        end
        S_RDD: if (mem_ack) begin
          dbuf <= mem_rdata;
          st   <= S_WRD;
        end
        S_WRD: if (skip || mem_ack) st <= (op == OP_SWAP) ? S_WRS : S_ADV;
        S_WRS: if (skip || mem_ack) st <= S_ADV;
        S_ADV: begin
          if (!modm)        cnt <= cnt - CW'(1);
          else if (row_end) cnt <= {cnt[CW-1:H] - H'(1), col_init};
          else              cnt[H-1:0] <= cnt[H-1:0] - H'(1);
          st <= last ? S_IDLE : (is_fill ? S_WRD : S_RDS);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_exec_engine_chk.sv
module dma_exec_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_dst,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          src_step,
  input logic          dst_step,
  input logic          src_row,
  input logic          dst_row
);
  assert_hold_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_dst) && $stable(mem_wdata));

  assert_no_step_in_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !src_step && !dst_step);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_row_with_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_row || dst_row) |-> dst_step);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !dst_step && !src_step && !done);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start |=> busy);
endmodule

bind dma_exec_engine dma_exec_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_dst(mem_dst), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .src_step(src_step), .dst_step(dst_step),
  .src_row(src_row), .dst_row(dst_row)
);

// File: tb/dma_exec_engine_bench.sv
module dma_exec_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic [15:0] count = '0;
  logic        src_mod = 1'b0, dst_mod = 1'b0, key_en = 1'b0;
  logic [7:0]  fill_byte = '0, key_val = '0;
  logic        busy, done, mem_req, mem_we, mem_dst, mem_ack;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        src_step, dst_step, src_row, dst_row;

  dma_exec_engine u_dma_exec_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_byte(cmd_byte), .count(count),
    .src_mod(src_mod), .dst_mod(dst_mod), .fill_byte(fill_byte), .key_en(key_en),
    .key_val(key_val), .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_dst(mem_dst), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .src_step(src_step), .dst_step(dst_step), .src_row(src_row), .dst_row(dst_row)
  );

  logic [7:0] mem [0:1023];
  logic [7:0] expm [0:1023];
  int src_addr, dst_addr, smd, dmd;
  int wr_cnt, done_cnt, dsteps, cycles, lat;
  int n_checks = 0, n_errors = 0;
  bit timed_out = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat <= 0;
    end else begin
      src_addr <= src_addr + (src_step ? 1 : 0) + (src_row ? smd : 0);
      dst_addr <= dst_addr + (dst_step ? 1 : 0) + (dst_row ? dmd : 0);
      if (dst_step) dsteps <= dsteps + 1;
      if (mem_req && !mem_ack) begin
        if (lat == 0) begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            mem[(mem_dst ? dst_addr : src_addr) & 1023] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
          end else
            mem_rdata <= mem[(mem_dst ? dst_addr : src_addr) & 1023];
          lat <= $urandom % 3;
        end else
          lat <= lat - 1;
      end else
        mem_ack <= 1'b0;
    end
  end

  always @(negedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int e_wr, e_dst;

  task automatic mwr(input int a, input logic [7:0] v);
    if (!(key_en && v == key_val)) begin
      expm[a & 1023] = v;
      e_wr++;
    end
  endtask

  task automatic model(input int sbase, input int dbase);
    int s, d, rows, cols;
    logic [7:0] sv, dv, r;
    bit m;
    m = src_mod || dst_mod;
    rows = m ? (count[15:8] == 0 ? 256 : int'(count[15:8])) : 1;
    cols = m ? (count[7:0] == 0 ? 256 : int'(count[7:0])) : (count == 0 ? 65536 : int'(count));
    s = sbase; d = dbase; e_wr = 0;
    for (int ri = 0; ri < rows; ri++) begin
      for (int ci = 0; ci < cols; ci++) begin
        sv = expm[s & 1023]; dv = expm[d & 1023];
        case (cmd_byte[1:0])
          2'd0: mwr(d, sv);
          2'd1: begin
            r = ({8{cmd_byte[4]}} & ~sv & ~dv) | ({8{cmd_byte[5]}} & ~sv & dv)
              | ({8{cmd_byte[6]}} & sv & ~dv) | ({8{cmd_byte[7]}} & sv & dv);
            mwr(d, r);
          end
          2'd2: begin mwr(d, sv); mwr(s, dv); end
          default: mwr(d, fill_byte);
        endcase
        if (cmd_byte[1:0] != 2'd3) s++;
        d++;
        if (m && ci == cols - 1) begin
          if (src_mod && cmd_byte[1:0] != 2'd3) s += smd;
          if (dst_mod) d += dmd;
        end
      end
    end
    e_dst = d;
  endtask

  task automatic run(input string req, input int sbase, input int dbase, input bit poke);
    int mism, t;
    logic [7:0] saved;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'($urandom % 4);
      expm[i] = mem[i];
    end
    model(sbase, dbase);
    @(negedge clk);
    src_addr = sbase; dst_addr = dbase;
    wr_cnt = 0; done_cnt = 0; dsteps = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      saved = cmd_byte;
      cmd_byte = ~cmd_byte;
      fill_byte = ~fill_byte;
      start = busy;
      @(negedge clk);
      start = 1'b0;
      cmd_byte = saved;
      fill_byte = ~fill_byte;
    end
    t = 0;
    while (busy && t < 150000 && !timed_out) begin
      @(negedge clk);
      t++;
    end
    if (busy) begin
      timed_out = 1;
      chk(0, "watchdog", t, 0);
    end
    repeat (2) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) mism++;
    chk(mism == 0, req, mism, 0);
    chk(wr_cnt == e_wr, {req, " write count R7"}, wr_cnt, e_wr);
    chk(dst_addr == e_dst, {req, " destination advance R6"}, dst_addr, e_dst);
    chk(done_cnt == 1, "done pulses R8", done_cnt, 1);
    chk(!busy, "idle after done R8", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    smd = 0; dmd = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "reset state R10", {busy, done, mem_req}, 0);
    chk(!src_step && !dst_step && !src_row && !dst_row, "reset pulses R10",
        {src_step, dst_step, src_row, dst_row}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cmd_byte = 8'h00; count = 16'd5; run("copy R1", 16, 600, 0);
    cmd_byte = 8'h61; count = 16'd7; run("mix xor R2", 40, 520, 0);
    cmd_byte = 8'h11; count = 16'd3; run("mix nor R2", 40, 520, 0);
    cmd_byte = 8'h02; count = 16'd6; run("swap R3", 100, 700, 0);
    cmd_byte = 8'h03; count = 16'd9; fill_byte = 8'h5a; run("fill R4", 0, 530, 0);
    key_en = 1; key_val = 8'd2;
    cmd_byte = 8'h02; count = 16'd8; run("swap with key R7", 10, 560, 0);
    key_en = 0;
    cmd_byte = 8'h00; count = 16'd6; run("start while busy R9", 20, 620, 1);

    src_mod = 0; dst_mod = 1; dmd = 3;
    cmd_byte = 8'h00; count = 16'h0100; run("modulo column zero R6", 0, 512, 0);
    src_mod = 0; dst_mod = 0; dmd = 0;
    src_mod = 1; smd = 0; cmd_byte = 8'h03; fill_byte = 8'h33; count = 16'h0002;
    run("modulo row zero R6", 0, 512, 0);
    src_mod = 0; smd = 0;

    for (int k = 0; k < 30; k++) begin
      cmd_byte = {4'($urandom), 2'b00, 2'($urandom)};
      fill_byte = 8'($urandom % 4);
      key_en = ($urandom % 4) == 0;
      key_val = 8'($urandom % 4);
      if ($urandom % 2) begin
        src_mod = $urandom % 2; dst_mod = !src_mod || ($urandom % 2);
        smd = $urandom % 5; dmd = $urandom % 5;
        count = {8'(1 + $urandom % 4), 8'(1 + $urandom % 6)};
      end else begin
        src_mod = 0; dst_mod = 0; smd = 0; dmd = 0;
        count = 16'(1 + $urandom % 24);
      end
      run("random R1 R2 R3 R4 R5 R6 R7", 32 + k, 560 + k, (k % 5) == 0);
    end
    src_mod = 0; dst_mod = 0; smd = 0; dmd = 0;

    key_en = 1; key_val = 8'h77; fill_byte = 8'h77; cmd_byte = 8'h03; count = 16'd0;
    run("linear count zero R5", 0, 512, 0);
    chk(dsteps == 65536, "65536 iterations R5", dsteps, 65536);
    key_en = 0;

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    wait (cycles > 195000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 195000);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule